// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block steers a CAN node out of the bus-off state. When the fault-confinement logic signals that the node has gone bus-off, the sequencer raises the node's initialization-request bit by itself. This halts all bus traffic from the node. It then holds there until software clears that bit. The sequencer does not stop the host from toggling the bit, but any toggle only pauses the sequence, so the host cannot shorten recovery.

Once the bit is clear, the sequencer watches the sampled receive stream. It counts runs of eleven consecutive recessive samples and needs 129 such runs to finish. Each run is reported through a one-cycle strobe, and the last-error field takes the bit-0-error code. The receive error counter shows how many runs have been seen so far, so software can follow progress and can tell a bus stuck at dominant from a slow but healthy one. When the final run completes, both error counters return to zero and the bus-off flag drops.

Top module: `busoff_recovery_seq`

## Requirements
- R1: After a synchronous reset the outputs are: init_q=1, boff_q=0, rec_cnt=0, tec_cnt=0, lec=7 (no change), b0err_stb=0 and warn=0.
- R2: A boff_enter pulse while boff_q=0 gives, in the next cycle, boff_q=1, init_q=1, rec_cnt=0 and tec_cnt=TEC_BOFF (255 by default). A boff_enter pulse while boff_q=1 has no effect.
- R3: A sample only counts toward a run while boff_q=1 and init_q=0. In any other state, samples change neither rec_cnt nor b0err_stb.
- R4: While counting, the eleventh consecutive recessive sample (smp_vld=1 and smp_bit=1) completes a run. In the next cycle rec_cnt rises by one, b0err_stb is high for exactly one cycle, and lec becomes 5 (bit-0 error).
- R5: A dominant sample (smp_vld=1 and smp_bit=0) resets the count of consecutive recessive samples to 0 and keeps rec_cnt. Cycles with smp_vld=0 leave the count unchanged.
- R6: Runs do not overlap: after a run completes, the count of consecutive samples restarts at 0, so 22 consecutive recessive samples give exactly two runs.
- R7: The 129th run ends recovery. In the next cycle boff_q=0, rec_cnt=0 and tec_cnt=0, b0err_stb=1, and init_q stays 0.
- R8: Setting init_q during recovery pauses counting, discards the partial run and keeps rec_cnt. Clearing init_q resumes from that rec_cnt. When set and clear requests arrive in the same cycle, the set wins.
- R9: warn is 1 exactly when rec_cnt or tec_cnt is at or above WARN_LIM (96), in the same cycle as those counter values.
- R10: lec keeps its value between runs, and keeps it after recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe marking a sampled bus bit |
| smp_bit | input | 1 | Sampled bit value, 1 = recessive |
| boff_enter | input | 1 | Pulse: node has entered bus-off |
| cpu_init_set | input | 1 | Software request to set the init bit |
| cpu_init_clr | input | 1 | Software request to clear the init bit |
| init_q | output | 1 | Initialization-request bit |
| boff_q | output | 1 | Bus-off flag |
| rec_cnt | output | ERR_W | Receive error counter, holds the completed-run count during recovery |
| tec_cnt | output | ERR_W | Transmit error counter |
| lec | output | 3 | Last error code, 7 = no change, 5 = bit-0 error |
| b0err_stb | output | 1 | One-cycle strobe for each completed idle run |
| warn | output | 1 | Error warning flag |

## Verification
The assertions check the rules that hold on every cycle. These are: the automatic setting of init on bus-off entry, no strobe while recovery is paused, the error code and the single-step counter increment that come with each strobe, the receive counter holding still between strobes, the warning flag tracking the counters, and the state at the moment recovery ends. Some behaviour depends on sample history and only the bench's scenarios can show it. That covers the reset of a partial run by a dominant sample, strobes never overlapping, a pause discarding a partial run, sample gaps, and the fact that exactly 129 runs are needed. A behavioural reference model compares every output on every clock.

// File: rtl/bor_pkg.sv
package bor_pkg;
  typedef logic [2:0] lec_t;
  localparam lec_t LEC_NOCHANGE = 3'd7;
  localparam lec_t LEC_BIT0     = 3'd5;

  typedef enum logic [1:0] {
    PH_NORMAL = 2'd0,
    PH_WAIT   = 2'd1,
    PH_COUNT  = 2'd2
  } phase_e;
endpackage

// File: rtl/bor_phase_ctrl.sv
module bor_phase_ctrl (
  input  logic            clk,
  input  logic            rst,
  input  logic            boff_enter,
  input  logic            cpu_init_set,
  input  logic            cpu_init_clr,
  input  logic            recov_done,
  output logic            init_q,
  output logic            boff_q,
  output logic            boff_start,
  output bor_pkg::phase_e phase
);
  import bor_pkg::*;

  // a new bus-off event is accepted only outside bus-off
  assign boff_start = boff_enter & ~boff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b1;
      boff_q <= 1'b0;
    end else if (boff_start) begin
      boff_q <= 1'b1;
      init_q <= 1'b1;
    end else begin
      if (recov_done) boff_q <= 1'b0;
      if (cpu_init_set)      init_q <= 1'b1;
      else if (cpu_init_clr) init_q <= 1'b0;
    end
  end

  always_comb begin
    if (!boff_q)     phase = PH_NORMAL;
    else if (init_q) phase = PH_WAIT;
    else             phase = PH_COUNT;
  end
endmodule

// File: rtl/bor_run_detect.sv
module bor_run_detect #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  input  logic smp_vld,
  input  logic smp_bit,
  output logic run_hit
);
  localparam int BW = $clog2(RUN_LEN + 1);
  localparam logic [BW-1:0] LAST = BW'(RUN_LEN - 1);

  logic [BW-1:0] bit_cnt;

  assign run_hit = count_en & smp_vld & smp_bit & (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !count_en) begin
      bit_cnt <= '0;
    end else if (smp_vld) begin
      if (!smp_bit || run_hit) bit_cnt <= '0;
      else                     bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bor_err_track.sv
module bor_err_track #(
  parameter int ERR_W      = 8,
  parameter int RUN_TARGET = 129,
  parameter int TEC_BOFF   = 255,
  parameter int WARN_LIM   = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boff_start,
  input  logic             run_hit,
  output logic             recov_done,
  output logic [ERR_W-1:0] rec_q,
  output logic [ERR_W-1:0] tec_q,
  output bor_pkg::lec_t    lec_q,
  output logic             stb_q,
  output logic             warn_q
);
  import bor_pkg::*;

  localparam logic [ERR_W-1:0] REC_LAST = ERR_W'(RUN_TARGET - 1);
  localparam logic [ERR_W-1:0] TEC_INIT = ERR_W'(TEC_BOFF);
  localparam logic [ERR_W-1:0] WARN_V   = ERR_W'(WARN_LIM);

  logic [ERR_W-1:0] rec_nx, tec_nx;

  assign recov_done = run_hit & (rec_q == REC_LAST);

  always_comb begin
    rec_nx = rec_q;
    tec_nx = tec_q;
    if (boff_start) begin
      rec_nx = '0;
      tec_nx = TEC_INIT;
    end else if (recov_done) begin
      rec_nx = '0;
      tec_nx = '0;
    end else if (run_hit) begin
      rec_nx = rec_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= '0;
      tec_q  <= '0;
      lec_q  <= LEC_NOCHANGE;
      stb_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      rec_q  <= rec_nx;
      tec_q  <= tec_nx;
      stb_q  <= run_hit;
      if (run_hit) lec_q <= LEC_BIT0;
      warn_q <= (rec_nx >= WARN_V) | (tec_nx >= WARN_V);
    end
  end
endmodule

// File: rtl/busoff_recovery_seq.sv
module busoff_recovery_seq #(
  parameter int RUN_LEN    = 11,
  parameter int RUN_TARGET = 129,
  parameter int ERR_W      = 8,
  parameter int TEC_BOFF   = 255,
  parameter int WARN_LIM   = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic             smp_bit,
  input  logic             boff_enter,
  input  logic             cpu_init_set,
  input  logic             cpu_init_clr,
  output logic             init_q,
  output logic             boff_q,
  output logic [ERR_W-1:0] rec_cnt,
  output logic [ERR_W-1:0] tec_cnt,
  output logic [2:0]       lec,
  output logic             b0err_stb,
  output logic             warn
);
  import bor_pkg::*;

  phase_e phase;
  logic   boff_start, run_hit, recov_done;

  bor_phase_ctrl u_phase (
    .clk(clk), .rst(rst), .boff_enter(boff_enter),
    .cpu_init_set(cpu_init_set), .cpu_init_clr(cpu_init_clr),
    .recov_done(recov_done), .init_q(init_q), .boff_q(boff_q),
    .boff_start(boff_start), .phase(phase)
  );

  bor_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .count_en(phase == PH_COUNT),
    .smp_vld(smp_vld), .smp_bit(smp_bit), .run_hit(run_hit)
  );

  bor_err_track #(
    .ERR_W(ERR_W), .RUN_TARGET(RUN_TARGET),
    .TEC_BOFF(TEC_BOFF), .WARN_LIM(WARN_LIM)
  ) u_err (
    .clk(clk), .rst(rst), .boff_start(boff_start), .run_hit(run_hit),
    .recov_done(recov_done), .rec_q(rec_cnt), .tec_q(tec_cnt),
    .lec_q(lec), .stb_q(b0err_stb), .warn_q(warn)
  );
endmodule

// File: rtl/bor_checker.sv
module bor_checker #(
  parameter int ERR_W    = 8,
  parameter int WARN_LIM = 96
) (
  input logic             clk,
  input logic             rst,
  input logic             boff_enter,
  input logic             init_q,
  input logic             boff_q,
  input logic [ERR_W-1:0] rec_cnt,
  input logic [ERR_W-1:0] tec_cnt,
  input logic [2:0]       lec,
  input logic             b0err_stb,
  input logic             warn
);
  localparam logic [ERR_W-1:0] WARN_V = ERR_W'(WARN_LIM);

  p_entry_sets_init_r2: assert property (@(posedge clk) disable iff (rst)
    (boff_enter && !boff_q) |=> (init_q && boff_q && rec_cnt == '0));

  p_paused_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (!boff_q || init_q) |=> !b0err_stb);

  p_strobe_code_r4: assert property (@(posedge clk) disable iff (rst)
    b0err_stb |-> (lec == 3'd5));

  p_rec_step_r4: assert property (@(posedge clk) disable iff (rst)
    (b0err_stb && boff_q) |-> (rec_cnt == $past(rec_cnt) + 1'b1));

  p_rec_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (boff_q && $past(boff_q) && !b0err_stb) |-> $stable(rec_cnt));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    b0err_stb |=> !b0err_stb);

  p_recovery_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(boff_q) |-> (rec_cnt == '0 && tec_cnt == '0 && b0err_stb && !init_q));

  p_warn_track_r9: assert property (@(posedge clk) disable iff (rst)
    warn == ((rec_cnt >= WARN_V) || (tec_cnt >= WARN_V)));
endmodule

bind busoff_recovery_seq bor_checker #(.ERR_W(ERR_W), .WARN_LIM(WARN_LIM)) u_chk (
  .clk(clk), .rst(rst), .boff_enter(boff_enter), .init_q(init_q),
  .boff_q(boff_q), .rec_cnt(rec_cnt), .tec_cnt(tec_cnt), .lec(lec),
  .b0err_stb(b0err_stb), .warn(warn)
);

// File: tb/sim_busoff_recovery_seq.sv
module sim_busoff_recovery_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN = 11;
  localparam int RUN_TARGET = 129;
  localparam int TEC_BOFF = 255;
  localparam int WARN_LIM = 96;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 0, smp_bit = 0, boff_enter = 0, cpu_init_set = 0, cpu_init_clr = 0;
  logic init_q, boff_q, b0err_stb, warn;
  logic [7:0] rec_cnt, tec_cnt;
  logic [2:0] lec;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_init = 1, m_boff = 0, m_rec = 0, m_tec = 0, m_lec = 7, m_stb = 0, m_warn = 0, m_bits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busoff_recovery_seq u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .boff_enter(boff_enter), .cpu_init_set(cpu_init_set), .cpu_init_clr(cpu_init_clr),
    .init_q(init_q), .boff_q(boff_q), .rec_cnt(rec_cnt), .tec_cnt(tec_cnt),
    .lec(lec), .b0err_stb(b0err_stb), .warn(warn)
  );

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    expect_eq(tag, "init_q", int'(init_q), m_init);
    expect_eq(tag, "boff_q", int'(boff_q), m_boff);
    expect_eq(tag, "rec_cnt", int'(rec_cnt), m_rec);
    expect_eq(tag, "tec_cnt", int'(tec_cnt), m_tec);
    expect_eq(tag, "lec", int'(lec), m_lec);
    expect_eq(tag, "b0err_stb", int'(b0err_stb), m_stb);
    expect_eq(tag, "warn", int'(warn), m_warn);
  endtask

  // advance the model from the current inputs, clock once, compare
  task automatic tick(string tag);
    bit counting, hit;
    counting = (m_boff == 1) && (m_init == 0);
    hit = 0;
    if (!counting) m_bits = 0;
    else if (smp_vld) begin
      if (smp_bit) begin
        if (m_bits == RUN_LEN - 1) begin hit = 1; m_bits = 0; end
        else m_bits++;
      end else m_bits = 0;
    end
    m_stb = hit;
    if (hit) m_lec = 5;
    if (boff_enter && m_boff == 0) begin
      m_boff = 1; m_init = 1; m_rec = 0; m_tec = TEC_BOFF;
    end else begin
      if (hit) begin
        if (m_rec == RUN_TARGET - 1) begin m_rec = 0; m_tec = 0; m_boff = 0; end
        else m_rec++;
      end
      if (cpu_init_set) m_init = 1;
      else if (cpu_init_clr) m_init = 0;
    end
    m_warn = (m_rec >= WARN_LIM || m_tec >= WARN_LIM) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    smp_vld = 0; smp_bit = 0; boff_enter = 0; cpu_init_set = 0; cpu_init_clr = 0;
  endtask

  task automatic sample(bit b, string tag);
    smp_vld = 1; smp_bit = b;
    tick(tag);
  endtask

  task automatic run_of(int n, string tag);
    for (int i = 0; i < n; i++) sample(1'b1, tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all("R1");
    // outside bus-off: samples never count, init freely toggled
    cpu_init_clr = 1; tick("R3");
    run_of(25, "R3");
    expect_eq("R3", "rec outside bus-off", int'(rec_cnt), 0);
    // bus-off entry
    boff_enter = 1; tick("R2");
    expect_eq("R2", "tec at entry", int'(tec_cnt), TEC_BOFF);
    expect_eq("R2", "init auto set", int'(init_q), 1);
    // waiting for software: samples ignored
    run_of(30, "R3");
    // set and clear together: set wins
    cpu_init_set = 1; cpu_init_clr = 1; tick("R8");
    expect_eq("R8", "set wins", int'(init_q), 1);
    cpu_init_clr = 1; tick("R8");
    // first run
    run_of(10, "R4");
    expect_eq("R4", "no strobe before 11th", int'(b0err_stb), 0);
    sample(1'b1, "R4");
    expect_eq("R4", "strobe", int'(b0err_stb), 1);
    expect_eq("R4", "rec after run", int'(rec_cnt), 1);
    expect_eq("R4", "lec bit0", int'(lec), 5);
    tick("R10");
    expect_eq("R10", "lec held", int'(lec), 5);
    // dominant resets partial run, gaps do not
    run_of(7, "R5");
    sample(1'b0, "R5");
    run_of(5, "R5");
    tick("R5"); tick("R5");
    run_of(5, "R5");
    expect_eq("R5", "no run yet", int'(rec_cnt), 1);
    sample(1'b1, "R5");
    expect_eq("R5", "run after reset", int'(rec_cnt), 2);
    // non-overlapping runs
    run_of(22, "R6");
    expect_eq("R6", "two runs from 22", int'(rec_cnt), 4);
    // pause mid run
    run_of(6, "R8");
    cpu_init_set = 1; tick("R8");
    run_of(15, "R8");
    expect_eq("R8", "rec kept in pause", int'(rec_cnt), 4);
    cpu_init_clr = 1; tick("R8");
    run_of(5, "R8");
    expect_eq("R8", "partial discarded", int'(rec_cnt), 4);
    run_of(6, "R8");
    expect_eq("R8", "resumed", int'(rec_cnt), 5);
    // second entry pulse ignored
    boff_enter = 1; tick("R2");
    expect_eq("R2", "entry ignored init", int'(init_q), 0);
    expect_eq("R2", "entry ignored rec", int'(rec_cnt), 5);
    // bulk runs through the warning threshold
    for (int r = 0; r < RUN_TARGET - 6; r++) run_of(RUN_LEN, "R9");
    expect_eq("R9", "rec before last", int'(rec_cnt), RUN_TARGET - 1);
    expect_eq("R9", "warn high", int'(warn), 1);
    run_of(RUN_LEN, "R7");
    expect_eq("R7", "boff cleared", int'(boff_q), 0);
    expect_eq("R7", "rec zero", int'(rec_cnt), 0);
    expect_eq("R7", "tec zero", int'(tec_cnt), 0);
    expect_eq("R7", "init stays clear", int'(init_q), 0);
    run_of(RUN_LEN, "R10");
    expect_eq("R10", "lec after end", int'(lec), 5);
    expect_eq("R3", "no count after end", int'(rec_cnt), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule